// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host end of a three-wire link to a serial-input digital-to-analog converter. A client hands it a 16-bit output code and a 2-bit power mode over a valid/ready handshake. The block turns them into one 24-bit word and shifts it out on an active-low frame select, a serial clock and a data line. The converter latches data on falling clock edges. Every interval the converter needs is counted in system-clock cycles set by parameters: the frame-select lead before the first falling edge, each clock phase, the tail before frame select rises, and the minimum frame-select high time between words. Elaboration rejects any setting that falls below the converter's minimum times at the stated system-clock period.

A request can also ask for byte-burst delivery. The word then goes out as three 8-bit groups with a longer clock-high pause between groups. This suits hosts whose serial engine moves one byte at a time. Frame select stays low across all three groups, and the bit order is still most significant first.

Top module: `dac_frame_tx`

## Requirements
- R1: While reset is held and just after it, frame select is high, the serial clock is high, data is 0, busy is 0 and ready is 1.
- R2: Each word is 24 bits, most significant first: bits 23 to 18 are zero, bits 17 to 16 carry the mode, and bits 15 to 0 carry the code.
- R3: The serial clock rests high whenever frame select is high. While frame select is low, the data line changes only in the cycle where the serial clock rises.
- R4: Frame select is low for exactly LEAD_CYC cycles before the first falling clock edge of a word, and the first data bit is already on the line when frame select falls.
- R5: Each low phase and each ordinary high phase of the serial clock lasts HALF_DIV cycles.
- R6: A word has exactly 24 falling clock edges. Frame select rises TAIL_CYC cycles after the clock returns high following the 24th fall.
- R7: After frame select rises it stays high for at least GAP_CYC cycles. busy is 1 from acceptance until that gap has elapsed, and ready is its inverse.
- R8: When the burst input is 1 at acceptance, the high phases after bit 8 and bit 16 (counted from the first bit sent) last HALF_DIV + BYTE_GAP_CYC cycles. Frame select stays low across all three bytes.
- R9: A request is taken only in a cycle where ready is 1. The code, mode and burst inputs are captured at that moment, and anything on them while busy has no effect on the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_code_i | input | 16 | Output code to send |
| req_mode_i | input | 2 | Power-mode field to send |
| req_burst_i | input | 1 | Send the word as three byte groups |
| busy_o | output | 1 | Word or trailing gap in progress |
| sync_n_o | output | 1 | Frame select, active low |
| sclk_o | output | 1 | Serial clock, rests high |
| din_o | output | 1 | Serial data |

## Verification
Two things can meet in one cycle. The first is a fresh request and the last cycle of the inter-word gap. The second is a byte boundary and the clock-rising edge that puts the next bit on the line. The bench holds valid high through each gap, so the next word is taken on the first ready cycle. It also sends burst words back to back, so the lengthened high phase and the data change land on the same edge. A per-cycle model built from the requirements predicts every pin in every cycle. A receiver model checks the captured word, the falling-edge count, the number of long pauses and the high time between words.

// File: rtl/dft_pkg.sv
// Package: shared sequencing states for the serial DAC frame writer.
// Assumes nothing beyond a 3-bit state encoding being sufficient.
package dft_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } dft_state_e;
endpackage

// File: rtl/dft_phase_timer.sv
// Module: loadable down counter that times every interval of the frame.
// Assumes the loader writes (length - 1) so the interval spans `length` cycles;
// done is high while the count sits at zero.
module dft_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down towards zero, or restart from a new length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dft_frame_shifter.sv
// Module: holds the outgoing word and presents its MSB as the data line.
// Assumes load, shift and clear are mutually exclusive. It tracks the bit
// index and the position within a byte so the sequencer can find the last
// bit and byte boundaries.
module dft_frame_shifter #(
    parameter int CODE_W  = 16,
    parameter int MODE_W  = 2,
    parameter int FRAME_W = 24,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              clear_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              bit_o,
    output logic              last_o,
    output logic              byte_end_o
);
    localparam int PAD_W  = FRAME_W - MODE_W - CODE_W;
    localparam int IDX_W  = $clog2(FRAME_W);
    localparam int BPOS_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [FRAME_W-1:0] word_d;
    logic [FRAME_W-1:0] word_q;
    logic [IDX_W-1:0]   idx_q;
    logic [BPOS_W-1:0]  bpos_q;

    // Assemble the word: zero padding on top, then mode, then code.
    generate
        if (PAD_W > 0) begin : g_pad
            assign word_d = {{PAD_W{1'b0}}, mode_i, code_i};
        end else begin : g_nopad
            assign word_d = {mode_i, code_i};
        end
    endgenerate

    // Load, shift left with zero fill, or clear the word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= word_d;
        end else if (shift_i) begin
            word_q <= {word_q[FRAME_W-2:0], 1'b0};
        end else if (clear_i) begin
            word_q <= '0;
        end
    end

    // Track the index of the bit on the line and its place in the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            idx_q  <= '0;
            bpos_q <= '0;
        end else if (shift_i) begin
            idx_q  <= idx_q + 1'b1;
            bpos_q <= (bpos_q == BPOS_W'(BYTE_W - 1)) ? '0 : bpos_q + 1'b1;
        end
    end

    assign bit_o      = word_q[FRAME_W-1];
    assign last_o     = (idx_q == IDX_W'(FRAME_W - 1));
    assign byte_end_o = (bpos_q == BPOS_W'(BYTE_W - 1));
endmodule

// File: rtl/dft_sequencer.sv
// Module: frame state machine driving frame select and the serial clock.
// Assumes the timer reports done in the last cycle of each interval and that
// the shifter's last and byte-end flags describe the bit on the line.
module dft_sequencer
    import dft_pkg::*;
#(
    parameter int CNT_W        = 5,
    parameter int HALF_DIV     = 5,
    parameter int LEAD_CYC     = 4,
    parameter int TAIL_CYC     = 2,
    parameter int GAP_CYC      = 9,
    parameter int BYTE_GAP_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_burst_i,
    output logic             req_ready_o,
    output logic             busy_o,
    input  logic             tmr_done_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    input  logic             last_i,
    input  logic             byte_end_i,
    output logic             sh_load_o,
    output logic             sh_shift_o,
    output logic             sh_clear_o,
    output logic             sync_n_o,
    output logic             sclk_o
);
    dft_state_e state_q;
    logic       sync_q;
    logic       sclk_q;
    logic       burst_q;
    logic       fire;

    assign fire        = (state_q == ST_IDLE) && req_valid_i;
    assign req_ready_o = (state_q == ST_IDLE);
    assign busy_o      = (state_q != ST_IDLE);

    // Advance the frame state and drive the two timing pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sync_q  <= 1'b1;
            sclk_q  <= 1'b1;
            burst_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (fire) begin
                    state_q <= ST_LEAD;
                    sync_q  <= 1'b0;
                    burst_q <= req_burst_i;
                end
                ST_LEAD: if (tmr_done_i) begin
                    state_q <= ST_LOW;
                    sclk_q  <= 1'b0;
                end
                ST_LOW: if (tmr_done_i) begin
                    sclk_q  <= 1'b1;
                    state_q <= last_i ? ST_TAIL : ST_HIGH;
                end
                ST_HIGH: if (tmr_done_i) begin
                    state_q <= ST_LOW;
                    sclk_q  <= 1'b0;
                end
                ST_TAIL: if (tmr_done_i) begin
                    state_q <= ST_GAP;
                    sync_q  <= 1'b1;
                end
                ST_GAP: if (tmr_done_i) begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pick the next interval length and the shifter action for each step.
    always_comb begin
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        sh_load_o  = 1'b0;
        sh_shift_o = 1'b0;
        sh_clear_o = 1'b0;
        case (state_q)
            ST_IDLE: if (fire) begin
                tmr_load_o = 1'b1;
                tmr_val_o  = CNT_W'(LEAD_CYC - 1);
                sh_load_o  = 1'b1;
            end
            ST_LEAD, ST_HIGH: if (tmr_done_i) begin
                tmr_load_o = 1'b1;
                tmr_val_o  = CNT_W'(HALF_DIV - 1);
            end
            ST_LOW: if (tmr_done_i) begin
                tmr_load_o = 1'b1;
                if (last_i) begin
                    tmr_val_o = CNT_W'(TAIL_CYC - 1);
                end else begin
                    sh_shift_o = 1'b1;
                    tmr_val_o  = (burst_q && byte_end_i)
                               ? CNT_W'(HALF_DIV + BYTE_GAP_CYC - 1)
                               : CNT_W'(HALF_DIV - 1);
                end
            end
            ST_TAIL: if (tmr_done_i) begin
                tmr_load_o = 1'b1;
                tmr_val_o  = CNT_W'(GAP_CYC - 1);
                sh_clear_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign sync_n_o = sync_q;
    assign sclk_o   = sclk_q;
endmodule

// File: rtl/dac_frame_tx.sv
// Module: top of the serial DAC frame writer. Takes a code and mode by
// handshake and sends them as one 24-bit word, optionally in byte groups.
// Assumes CLK_NS is the system-clock period in ns; elaboration checks the
// cycle parameters against the converter's minimum times.
module dac_frame_tx #(
    parameter int CODE_W       = 16,
    parameter int MODE_W       = 2,
    parameter int FRAME_W      = 24,
    parameter int BYTE_W       = 8,
    parameter int CLK_NS       = 4,
    parameter int HALF_DIV     = 5,
    parameter int LEAD_CYC     = 4,
    parameter int TAIL_CYC     = 2,
    parameter int GAP_CYC      = 9,
    parameter int BYTE_GAP_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [CODE_W-1:0] req_code_i,
    input  logic [MODE_W-1:0] req_mode_i,
    input  logic              req_burst_i,
    output logic              busy_o,
    output logic              sync_n_o,
    output logic              sclk_o,
    output logic              din_o
);
    localparam int MAX_A   = (HALF_DIV + BYTE_GAP_CYC > LEAD_CYC) ? HALF_DIV + BYTE_GAP_CYC : LEAD_CYC;
    localparam int MAX_B   = (GAP_CYC > TAIL_CYC) ? GAP_CYC : TAIL_CYC;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    // Elaboration checks against the converter's minimum times.
    generate
        if (HALF_DIV * CLK_NS < 13 || 2 * HALF_DIV * CLK_NS < 33) begin : g_bad_clock
            $error("serial clock phase or period below converter minimum");
        end
        if (LEAD_CYC * CLK_NS < 13) begin : g_bad_lead
            $error("frame select lead below converter minimum");
        end
        if (GAP_CYC * CLK_NS < 33) begin : g_bad_gap
            $error("frame select high time below converter minimum");
        end
        if (TAIL_CYC < 1 || FRAME_W < MODE_W + CODE_W) begin : g_bad_shape
            $error("tail or frame width out of range");
        end
    endgenerate

    logic             tmr_done;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_clear;
    logic             last_bit;
    logic             byte_end;

    dft_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    dft_frame_shifter #(
        .CODE_W (CODE_W),
        .MODE_W (MODE_W),
        .FRAME_W(FRAME_W),
        .BYTE_W (BYTE_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .shift_i    (sh_shift),
        .clear_i    (sh_clear),
        .code_i     (req_code_i),
        .mode_i     (req_mode_i),
        .bit_o      (din_o),
        .last_o     (last_bit),
        .byte_end_o (byte_end)
    );

    dft_sequencer #(
        .CNT_W       (CNT_W),
        .HALF_DIV    (HALF_DIV),
        .LEAD_CYC    (LEAD_CYC),
        .TAIL_CYC    (TAIL_CYC),
        .GAP_CYC     (GAP_CYC),
        .BYTE_GAP_CYC(BYTE_GAP_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_burst_i (req_burst_i),
        .req_ready_o (req_ready_o),
        .busy_o      (busy_o),
        .tmr_done_i  (tmr_done),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .last_i      (last_bit),
        .byte_end_i  (byte_end),
        .sh_load_o   (sh_load),
        .sh_shift_o  (sh_shift),
        .sh_clear_o  (sh_clear),
        .sync_n_o    (sync_n_o),
        .sclk_o      (sclk_o)
    );
endmodule

// File: rtl/dft_checker.sv
// Module: protocol checker for the frame writer's pins, bound to the top.
// Assumes synchronous active-low reset; counters saturate instead of wrapping.
module dft_checker #(
    parameter int FRAME_W  = 24,
    parameter int HALF_DIV = 5,
    parameter int LEAD_CYC = 4,
    parameter int GAP_CYC  = 9
) (
    input logic clk,
    input logic rst_n,
    input logic sync_n_o,
    input logic sclk_o,
    input logic din_o,
    input logic busy_o,
    input logic req_ready_o
);
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;
    logic [15:0] ph_cnt;
    logic [7:0]  falls;
    logic        sclk_d;

    // Measure frame-select high and low run lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 16'hFFFF;
            lo_cnt <= '0;
        end else if (sync_n_o) begin
            hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= '0;
            lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
        end
    end

    // Measure serial clock phase lengths and count falls within a word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            ph_cnt <= 16'hFFFF;
            falls  <= '0;
        end else begin
            sclk_d <= sclk_o;
            if (sclk_o != sclk_d) ph_cnt <= 16'd1;
            else if (ph_cnt != 16'hFFFF) ph_cnt <= ph_cnt + 1'b1;
            if (sync_n_o) falls <= '0;
            else if (sclk_d && !sclk_o) falls <= falls + 1'b1;
        end
    end

    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_o |-> sclk_o);

    p_din_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n_o && !$fell(sync_n_o) && din_o != $past(din_o)) |-> $rose(sclk_o));

    p_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk_o) && falls == 8'd0) |-> lo_cnt >= 16'(LEAD_CYC));

    p_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n_o && sclk_o != $past(sclk_o)) |-> ph_cnt >= 16'(HALF_DIV));

    p_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_o) |-> falls == 8'(FRAME_W));

    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n_o) |-> hi_cnt >= 16'(GAP_CYC));

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n_o |-> (busy_o && !req_ready_o));
endmodule

bind dac_frame_tx dft_checker #(
    .FRAME_W (FRAME_W),
    .HALF_DIV(HALF_DIV),
    .LEAD_CYC(LEAD_CYC),
    .GAP_CYC (GAP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n_o   (sync_n_o),
    .sclk_o     (sclk_o),
    .din_o      (din_o),
    .busy_o     (busy_o),
    .req_ready_o(req_ready_o)
);

// File: tb/sim_dac_frame_tx.sv
// Bench: per-cycle pin model plus a falling-edge receiver model.
module sim_dac_frame_tx;
    localparam int H = 5, L = 4, T = 2, G = 9, B = 6, NF = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [15:0] req_code_i = '0;
    logic [1:0]  req_mode_i = '0;
    logic        req_burst_i = 1'b0;
    logic        req_ready_o, busy_o, sync_n_o, sclk_o, din_o;

    always #2 clk = ~clk;

    dac_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_code_i(req_code_i), .req_mode_i(req_mode_i), .req_burst_i(req_burst_i),
        .busy_o(busy_o), .sync_n_o(sync_n_o), .sclk_o(sclk_o), .din_o(din_o)
    );

    typedef struct packed { logic s; logic c; logic d; logic b; } ent_t;
    localparam ent_t IDLE_E = '{s: 1'b1, c: 1'b1, d: 1'b0, b: 1'b0};

    ent_t        q[$];
    logic [23:0] fq[$];
    logic        bq[$];
    int          n_chk = 0, n_fail = 0;

    logic [15:0] f_code [NF] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001, 16'h7FFE};
    logic [1:0]  f_mode [NF] = '{2'b00, 2'b11, 2'b01, 2'b10, 2'b00};
    logic        f_burst[NF] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    int          f_start[NF] = '{0, 0, 600, 0, 0};

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_e(input logic s, input logic c, input logic d, input int n);
        for (int k = 0; k < n; k++) q.push_back('{s: s, c: c, d: d, b: 1'b1});
    endtask

    task automatic push_frame(input logic [23:0] f, input logic burst);
        push_e(1'b0, 1'b1, f[23], L);
        for (int i = 0; i < 24; i++) begin
            push_e(1'b0, 1'b0, f[23-i], H);
            if (i < 23) push_e(1'b0, 1'b1, f[22-i], (burst && (i % 8) == 7) ? H + B : H);
        end
        push_e(1'b0, 1'b1, f[0], T);
        push_e(1'b1, 1'b1, 1'b0, G);
        fq.push_back(f);
        bq.push_back(burst);
    endtask

    // Receiver model: sample on falling clock edges, judge the word at frame-select rise.
    logic [23:0] rx_sh = '0;
    int          rx_n = 0, long_n = 0;
    longint      t_rise_c = 0, t_hi = 0;
    bit          seen_hi = 1'b0;

    always @(posedge sclk_o) t_rise_c = $time;

    always @(negedge sclk_o) begin
        if (rst_n && !sync_n_o) begin
            if (rx_n > 0 && ($time - t_rise_c) > H * 4) long_n++;
            rx_sh = {rx_sh[22:0], din_o};
            rx_n++;
        end
    end

    always @(negedge sync_n_o) begin
        if (rst_n) begin
            if (seen_hi) chk(($time - t_hi) / 4 >= G + 1, "R7 high gap cycles", ($time - t_hi) / 4, G + 1);
            rx_n = 0;
            long_n = 0;
        end
    end

    always @(posedge sync_n_o) begin
        if (rst_n) begin
            logic [23:0] ef;
            logic        eb;
            ef = fq.size() > 0 ? fq.pop_front() : 24'hFFFFFF;
            eb = bq.size() > 0 ? bq.pop_front() : 1'b0;
            chk(rx_n == 24, "R6 falling edges per word", rx_n, 24);
            chk(rx_sh == ef, "R2 R9 received word", rx_sh, ef);
            chk(long_n == (eb ? 2 : 0), "R8 long high pauses", long_n, eb ? 2 : 0);
            t_hi = $time;
            seen_hi = 1'b1;
        end
    end

    initial begin
        int   cyc;
        int   p;
        int   idle_run;
        ent_t e;
        repeat (4) @(negedge clk);
        chk(sync_n_o == 1'b1 && sclk_o == 1'b1 && din_o == 1'b0, "R1 pins in reset",
            {sync_n_o, sclk_o, din_o}, 3'b110);
        chk(busy_o == 1'b0 && req_ready_o == 1'b1, "R1 handshake in reset", {busy_o, req_ready_o}, 2'b01);
        rst_n = 1'b1;
        cyc = 0;
        p = 0;
        idle_run = 0;
        forever begin
            @(negedge clk);
            cyc++;
            e = (q.size() > 0) ? q.pop_front() : IDLE_E;
            chk(sync_n_o == e.s, "R4 R7 frame select", sync_n_o, e.s);
            chk(sclk_o == e.c, "R3 R5 R8 serial clock", sclk_o, e.c);
            chk(din_o == e.d, "R2 R3 data line", din_o, e.d);
            chk(busy_o == e.b && req_ready_o == !e.b, "R7 R9 busy/ready", {busy_o, req_ready_o}, {e.b, !e.b});
            if (!e.b && p < NF && cyc >= f_start[p]) begin
                req_valid_i = 1'b1;
                req_code_i  = f_code[p];
                req_mode_i  = f_mode[p];
                req_burst_i = f_burst[p];
                push_frame({6'b0, f_mode[p], f_code[p]}, f_burst[p]);
                p++;
            end else if (e.b) begin
                req_valid_i = 1'b1;
                req_code_i  = 16'(cyc) ^ 16'h5A5A;
                req_mode_i  = 2'(cyc);
                req_burst_i = cyc[0];
            end else begin
                req_valid_i = 1'b0;
            end
            if (p == NF && q.size() == 0 && !e.b) idle_run++;
            if (idle_run > 4) break;
            if (cyc > 20000) begin
                chk(1'b0, "R7 watchdog expired", cyc, 20000);
                break;
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule